// File: doc/BRIEF.md
# Acquisition Command and Status Register Block

This block is the register front end of a multichannel analog acquisition card. It sits on a simple 16-bit write/read bus. It holds two write-only command words that steer the acquisition circuitry. The first command word shares its offset with a read-only status word. Four further offsets act as event strobes, and the value written to them does not matter. These strobes start a single conversion, start an acquisition, clear the A/D path and clear the acquisition-stop interrupt.

The converter, the sample FIFO and the counter/timer sit outside this block. They report to it through single-cycle event inputs: a sample was stored, a sample was read, the FIFO overflowed, a conversion overran, and the sample counter reached terminal count. The block keeps these events as sticky status flags. It tracks whether an acquisition is in progress. It drives one interrupt request, which is gated by enables held in both command words.

Top module: `daq_ctrl_regs`

## Requirements
- R1: After reset both command words, all strobe outputs, every status bit and the interrupt request are zero.
- R2: A write at offset 0x00 stores the full 16-bit word into command word 1, visible on `cmd1_o` from the next cycle. A read at 0x00 returns the status word and never returns command word 1.
- R3: A write at offset 0x02 stores the full word into command word 2. Bits 9 and 8 of that word drive `dout_en_o[1]` (lines 4-7) and `dout_en_o[0]` (lines 0-3).
- R4: A write at 0x08, 0x0A, 0x0C or 0x14 raises, for exactly the next cycle, `start_conv_o`, `start_acq_o`, `ad_clear_o` or `irq_clear_o` respectively, whatever the data. Such a write changes neither command word.
- R5: Status bit 13 (data available) sets on `sample_stored_i`. It clears on `sample_read_i` or on an A/D clear write, and a clear wins over a set in the same cycle.
- R6: Status bit 9 (FIFO overflow) and bit 8 (overrun) set on their event inputs. They stay set until an A/D clear write (clear wins), and an interrupt-clear write does not touch them.
- R7: Status bit 11 (acquisition in progress) sets on a start-acquisition write only while command word 1 bit 4 is set; otherwise that write leaves bit 11 at zero.
- R8: Bit 11 clears when `term_count_i` arrives (this wins over a same-cycle start) or when command word 1 bit 4 is zero. A terminal count while bit 11 is set raises status bit 14 (acquisition stopped).
- R9: An interrupt-clear write clears status bit 14, winning over a same-cycle set.
- R10: `irq_o` equals command word 2 bit 7 AND ((command word 1 bit 7 AND status bit 13) OR status bit 14).
- R11: Status bits other than 8, 9, 11, 13 and 14 read as zero, and a read at any offset other than 0x00 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 5 | Write byte offset |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 5 | Read byte offset |
| rd_data_o | output | 16 | Read data (status at 0x00, else zero) |
| sample_stored_i | input | 1 | Converter stored a sample in the FIFO |
| sample_read_i | input | 1 | A sample was taken from the FIFO |
| fifo_ovf_i | input | 1 | FIFO overflow event |
| overrun_i | input | 1 | Conversion overrun event |
| term_count_i | input | 1 | Sample counter reached terminal count |
| cmd1_o | output | 16 | Command word 1 |
| cmd2_o | output | 16 | Command word 2 |
| dout_en_o | output | 2 | Digital output nibble enables |
| start_conv_o | output | 1 | Start-conversion pulse |
| start_acq_o | output | 1 | Start-acquisition pulse |
| ad_clear_o | output | 1 | A/D clear pulse |
| irq_clear_o | output | 1 | Interrupt-clear pulse |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong flag inside the block shows at `status_o` and `rd_data_o` in the cycle after the offending event. If the matching enables are set, it also shows on `irq_o` in that same cycle, because the request is formed from the registered state with no further delay. A wrong decode shows one cycle after the write, either as a missing or extra strobe pulse or as a command word that changed when it should not have. The bench mixes random bus traffic with random event inputs. It compares every output against a cycle model at every cycle, so a divergence is caught at the first cycle it reaches a port.

// File: rtl/daq_regs_pkg.sv
package daq_regs_pkg;

    localparam int OFS_CMD1      = 'h00;
    localparam int OFS_CMD2      = 'h02;
    localparam int OFS_CONV_GO   = 'h08;
    localparam int OFS_ACQ_GO    = 'h0A;
    localparam int OFS_AD_CLEAR  = 'h0C;
    localparam int OFS_IRQ_CLEAR = 'h14;

    localparam int NUM_STROBES = 4;
    localparam int STB_CONV    = 0;
    localparam int STB_ACQ     = 1;
    localparam int STB_CLR     = 2;
    localparam int STB_IRQCLR  = 3;

    // command word 1 fields
    localparam int C1_ACQ_EN   = 4;
    localparam int C1_CONV_IE  = 7;
    // command word 2 fields
    localparam int C2_GIE      = 7;
    localparam int C2_DOUT_LO  = 8;

    // status word fields
    localparam int ST_OVERRUN  = 8;
    localparam int ST_OVERFLOW = 9;
    localparam int ST_BUSY     = 11;
    localparam int ST_AVAIL    = 13;
    localparam int ST_STOPPED  = 14;

    typedef struct packed {
        logic stopped;
        logic avail;
        logic busy;
        logic overflow;
        logic overrun;
    } flags_t;

endpackage

// File: rtl/daq_wr_decode.sv
module daq_wr_decode
    import daq_regs_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    output logic                   sel_cmd1_o,
    output logic                   sel_cmd2_o,
    output logic [NUM_STROBES-1:0] evt_o
);
    localparam int STB_OFS [NUM_STROBES] = '{OFS_CONV_GO, OFS_ACQ_GO, OFS_AD_CLEAR, OFS_IRQ_CLEAR};

    assign sel_cmd1_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CMD1));
    assign sel_cmd2_o = wr_en_i && (wr_addr_i == ADDR_W'(OFS_CMD2));

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_stb
        assign evt_o[g] = wr_en_i && (wr_addr_i == ADDR_W'(STB_OFS[g]));
    end
endmodule

// File: rtl/daq_cmd_bank.sv
module daq_cmd_bank
    import daq_regs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_cmd1_i,
    input  logic                   sel_cmd2_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [NUM_STROBES-1:0] evt_i,
    output logic [DATA_W-1:0]      cmd1_o,
    output logic [DATA_W-1:0]      cmd2_o,
    output logic [NUM_STROBES-1:0] pulse_o
);
    typedef struct packed {
        logic [DATA_W-1:0]      cmd1;
        logic [DATA_W-1:0]      cmd2;
        logic [NUM_STROBES-1:0] pulse;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = evt_i;
        if (sel_cmd1_i) st_d.cmd1 = wr_data_i;
        if (sel_cmd2_i) st_d.cmd2 = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd1_o  = st_q.cmd1;
    assign cmd2_o  = st_q.cmd2;
    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/daq_status_unit.sv
module daq_status_unit
    import daq_regs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   acq_en_i,
    input  logic   acq_go_i,
    input  logic   ad_clear_i,
    input  logic   irq_clear_i,
    input  logic   sample_stored_i,
    input  logic   sample_read_i,
    input  logic   fifo_ovf_i,
    input  logic   overrun_i,
    input  logic   term_count_i,
    output flags_t flags_o
);
    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // data available: clears win over a new sample
        if (sample_read_i || ad_clear_i) fl_d.avail = 1'b0;
        else if (sample_stored_i)        fl_d.avail = 1'b1;
        // sticky error flags, only the A/D clear releases them
        if (ad_clear_i) begin
            fl_d.overflow = 1'b0;
            fl_d.overrun  = 1'b0;
        end else begin
            fl_d.overflow = fl_q.overflow | fifo_ovf_i;
            fl_d.overrun  = fl_q.overrun  | overrun_i;
        end
        // acquisition in progress
        if (!acq_en_i || term_count_i) fl_d.busy = 1'b0;
        else if (acq_go_i)             fl_d.busy = 1'b1;
        // acquisition stopped
        if (irq_clear_i)                      fl_d.stopped = 1'b0;
        else if (term_count_i && fl_q.busy)   fl_d.stopped = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q;
endmodule

// File: rtl/daq_ctrl_regs.sv
module daq_ctrl_regs
    import daq_regs_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              sample_stored_i,
    input  logic              sample_read_i,
    input  logic              fifo_ovf_i,
    input  logic              overrun_i,
    input  logic              term_count_i,
    output logic [DATA_W-1:0] cmd1_o,
    output logic [DATA_W-1:0] cmd2_o,
    output logic [1:0]        dout_en_o,
    output logic              start_conv_o,
    output logic              start_acq_o,
    output logic              ad_clear_o,
    output logic              irq_clear_o,
    output logic [DATA_W-1:0] status_o,
    output logic              irq_o
);
    logic                   sel_cmd1, sel_cmd2;
    logic [NUM_STROBES-1:0] evt, pulse;
    flags_t                 flags;

    daq_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .sel_cmd1_o (sel_cmd1),
        .sel_cmd2_o (sel_cmd2),
        .evt_o      (evt)
    );

    daq_cmd_bank #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_cmd1_i (sel_cmd1),
        .sel_cmd2_i (sel_cmd2),
        .wr_data_i  (wr_data_i),
        .evt_i      (evt),
        .cmd1_o     (cmd1_o),
        .cmd2_o     (cmd2_o),
        .pulse_o    (pulse)
    );

    daq_status_unit u_stat (
        .clk             (clk),
        .rst_n           (rst_n),
        .acq_en_i        (cmd1_o[C1_ACQ_EN]),
        .acq_go_i        (evt[STB_ACQ]),
        .ad_clear_i      (evt[STB_CLR]),
        .irq_clear_i     (evt[STB_IRQCLR]),
        .sample_stored_i (sample_stored_i),
        .sample_read_i   (sample_read_i),
        .fifo_ovf_i      (fifo_ovf_i),
        .overrun_i       (overrun_i),
        .term_count_i    (term_count_i),
        .flags_o         (flags)
    );

    always_comb begin
        status_o              = '0;
        status_o[ST_OVERRUN]  = flags.overrun;
        status_o[ST_OVERFLOW] = flags.overflow;
        status_o[ST_BUSY]     = flags.busy;
        status_o[ST_AVAIL]    = flags.avail;
        status_o[ST_STOPPED]  = flags.stopped;
    end

    assign rd_data_o    = (rd_addr_i == ADDR_W'(OFS_CMD1)) ? status_o : '0;
    assign dout_en_o    = cmd2_o[C2_DOUT_LO+1:C2_DOUT_LO];
    assign start_conv_o = pulse[STB_CONV];
    assign start_acq_o  = pulse[STB_ACQ];
    assign ad_clear_o   = pulse[STB_CLR];
    assign irq_clear_o  = pulse[STB_IRQCLR];
    assign irq_o        = cmd2_o[C2_GIE] &
                          ((cmd1_o[C1_CONV_IE] & flags.avail) | flags.stopped);
endmodule

// File: rtl/daq_ctrl_regs_chk.sv
module daq_ctrl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en_i,
    input logic [4:0]  wr_addr_i,
    input logic [15:0] cmd1_o,
    input logic [15:0] cmd2_o,
    input logic [15:0] status_o,
    input logic        start_conv_o,
    input logic        start_acq_o,
    input logic        ad_clear_o,
    input logic        irq_clear_o,
    input logic        irq_o
);
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_conv_o, start_acq_o, ad_clear_o, irq_clear_o}));

    // R4
    acq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 5'h0A) |=> start_acq_o);

    // R4
    strobe_keeps_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 5'h08) |=> ($stable(cmd1_o) && $stable(cmd2_o)));

    // R6
    ad_clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 5'h0C) |=> (status_o[9:8] == 2'b00 && !status_o[13]));

    // R8
    busy_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd1_o[4] |=> !status_o[11]);

    // R9
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 5'h14) |=> !status_o[14]);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cmd2_o[7]);

    // R11
    status_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & 16'h94FF) == 16'h0000);
endmodule

bind daq_ctrl_regs daq_ctrl_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .cmd1_o       (cmd1_o),
    .cmd2_o       (cmd2_o),
    .status_o     (status_o),
    .start_conv_o (start_conv_o),
    .start_acq_o  (start_acq_o),
    .ad_clear_o   (ad_clear_o),
    .irq_clear_o  (irq_clear_o),
    .irq_o        (irq_o)
);

// File: tb/daq_ctrl_regs_test.sv
module daq_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic        s_st = 1'b0, s_rd = 1'b0, s_ovf = 1'b0, s_ovr = 1'b0, s_tc = 1'b0;
    logic [15:0] rd_data, cmd1, cmd2, status;
    logic [1:0]  dout_en;
    logic        p_conv, p_acq, p_clr, p_iclr, irq;

    int n_cmp = 0, n_bad = 0;

    // bench model state
    logic [15:0] m_c1 = '0, m_c2 = '0;
    logic [3:0]  m_pulse = '0;
    logic        m_avail = 1'b0, m_ovf = 1'b0, m_ovr = 1'b0, m_busy = 1'b0, m_stop = 1'b0;

    always #4 clk = ~clk;

    daq_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .sample_stored_i(s_st), .sample_read_i(s_rd), .fifo_ovf_i(s_ovf),
        .overrun_i(s_ovr), .term_count_i(s_tc),
        .cmd1_o(cmd1), .cmd2_o(cmd2), .dout_en_o(dout_en),
        .start_conv_o(p_conv), .start_acq_o(p_acq), .ad_clear_o(p_clr),
        .irq_clear_o(p_iclr), .status_o(status), .irq_o(irq)
    );

    function automatic logic [15:0] exp_status();
        logic [15:0] s;
        s = '0;
        s[8] = m_ovr; s[9] = m_ovf; s[11] = m_busy; s[13] = m_avail; s[14] = m_stop;
        return s;
    endfunction

    function automatic logic exp_irq();
        return m_c2[7] & ((m_c1[7] & m_avail) | m_stop);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [15:0] es;
        es = exp_status();
        chk("R2 cmd1", cmd1, m_c1);
        chk("R3 cmd2", cmd2, m_c2);
        chk("R3 dout_en", {14'd0, dout_en}, {14'd0, m_c2[9:8]});
        chk("R4 strobes", {12'd0, p_iclr, p_clr, p_acq, p_conv}, {12'd0, m_pulse});
        chk("R5 avail", {15'd0, status[13]}, {15'd0, es[13]});
        chk("R6 ovf/ovr", {14'd0, status[9:8]}, {14'd0, es[9:8]});
        chk("R7/R8 busy", {15'd0, status[11]}, {15'd0, es[11]});
        chk("R8/R9 stopped", {15'd0, status[14]}, {15'd0, es[14]});
        chk("R11 status", status, es);
        chk("R11 rd_data", rd_data, (rd_addr == 5'h00) ? es : 16'h0000);
        chk("R10 irq", {15'd0, irq}, {15'd0, exp_irq()});
    endtask

    // model step using the pre-edge state and inputs
    task automatic model_step();
        logic we_c1, we_c2, go, clr, iclr;
        logic [15:0] c1_old;
        logic busy_old;
        we_c1 = wr_en && wr_addr == 5'h00;
        we_c2 = wr_en && wr_addr == 5'h02;
        go    = wr_en && wr_addr == 5'h0A;
        clr   = wr_en && wr_addr == 5'h0C;
        iclr  = wr_en && wr_addr == 5'h14;
        c1_old = m_c1; busy_old = m_busy;
        m_pulse = {iclr, clr, go, wr_en && wr_addr == 5'h08};
        if (we_c1) m_c1 = wr_data;
        if (we_c2) m_c2 = wr_data;
        if (s_rd || clr) m_avail = 1'b0; else if (s_st) m_avail = 1'b1;
        if (clr) begin m_ovf = 1'b0; m_ovr = 1'b0; end
        else begin m_ovf = m_ovf | s_ovf; m_ovr = m_ovr | s_ovr; end
        if (!c1_old[4] || s_tc) m_busy = 1'b0; else if (go) m_busy = 1'b1;
        if (iclr) m_stop = 1'b0; else if (s_tc && busy_old) m_stop = 1'b1;
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic we, input logic [4:0] a, input logic [15:0] d,
                       input logic [4:0] ev, input logic [4:0] ra);
        wr_en = we; wr_addr = a; wr_data = d; rd_addr = ra;
        {s_st, s_rd, s_ovf, s_ovr, s_tc} = ev;
        @(posedge clk);
        model_step();
        @(negedge clk);
        wr_en = 1'b0; {s_st, s_rd, s_ovf, s_ovr, s_tc} = '0;
        check_all();
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        cyc(1'b1, a, d, 5'b0, 5'h00);
    endtask

    task automatic ev(input logic [4:0] e);
        cyc(1'b0, 5'h00, 16'h0, e, 5'h00);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    localparam logic [4:0] ADDRS [8] = '{5'h00, 5'h02, 5'h08, 5'h0A, 5'h0C, 5'h14, 5'h10, 5'h16};

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cmd1", cmd1, 16'h0);
        chk("R1 cmd2", cmd2, 16'h0);
        chk("R1 status", status, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        chk("R1 strobes", {12'd0, p_iclr, p_clr, p_acq, p_conv}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: read at 0x00 gives status, not command word
        wr(5'h00, 16'hA5A5);
        // R4: strobe data ignored, command words untouched
        wr(5'h08, 16'hFFFF);
        wr(5'h14, 16'h1234);
        // R7: start without enable is ignored
        wr(5'h00, 16'h0000);
        wr(5'h0A, 16'hFFFF);
        // R7/R8: enable, start, terminal count raises stop
        wr(5'h00, 16'h0090);
        wr(5'h02, 16'h0380);
        wr(5'h0A, 16'h0000);
        ev(5'b00001);
        // R9 clear stop, R10 irq from data available
        wr(5'h14, 16'h0000);
        ev(5'b10000);
        // R5: read and store same cycle: clear wins
        ev(5'b11000);
        // R6: sticky until A/D clear; irq clear does not release them
        ev(5'b00110);
        wr(5'h14, 16'h0);
        wr(5'h0C, 16'h0);
        // R8: start and terminal count same cycle, terminal wins
        wr(5'h0A, 16'h0);
        cyc(1'b1, 5'h0A, 16'h0, 5'b00001, 5'h00);
        // R11: read of another offset
        cyc(1'b0, 5'h00, 16'h0, 5'b00110, 5'h02);

        for (int i = 0; i < 4000; i++) begin
            logic [4:0] e;
            e[4] = ($urandom % 4) == 0;
            e[3] = ($urandom % 5) == 0;
            e[2] = ($urandom % 16) == 0;
            e[1] = ($urandom % 16) == 0;
            e[0] = ($urandom % 12) == 0;
            cyc(($urandom % 2) == 1, ADDRS[$urandom % 8], 16'($urandom), e,
                (($urandom % 3) == 0) ? ADDRS[$urandom % 8] : 5'h00);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule